// File: doc/BRIEF.md
# MII UDP Frame Transmitter

This block sends a buffered run of payload bytes to a host as one complete Ethernet frame on a 100 Mb/s full-duplex MII transmit port. Each byte leaves as two nibbles, one nibble per cycle of the 25 MHz transmit clock. The frame carries a fixed IPv4 header and a fixed UDP header, so the host can receive it with an ordinary datagram socket bound to the fixed addresses. There is no MAC core behind it: the block builds every byte of the frame itself.

The IPv4 and UDP length fields depend on the payload size, so the payload must be known before the header goes out. The producer therefore writes the whole payload into a small internal store first, marking the final byte with a last flag, and then raises a start request. The block inserts both length fields and computes the IPv4 header checksum for the current length. It pads short payloads with zeros to the Ethernet minimum and appends the CRC32. A fixed idle gap follows every frame. The busy flag covers the frame and the gap. While busy is high, new payload bytes and start requests are ignored. When the gap ends, the store is emptied for the next payload.

Top module: `mii_udp_tx`

## Requirements
- R1: After reset, tx_en is 0, txd is 0 and busy is 0.
- R2: While busy is 0, each byte with pl_valid high is stored in arrival order, and the byte with pl_last high ends the payload. At most MAX_PAYLOAD (64) bytes are kept: bytes offered beyond that are dropped, but pl_last still ends the payload.
- R3: A start sampled while busy is 0 and a payload has been ended launches a frame. busy is high one cycle later and tx_en is high two cycles later. A start with no ended payload, or while busy is high, has no effect.
- R4: tx_en stays high for the whole frame. Each byte goes out as two nibbles on txd, the low nibble first. The frame opens with seven bytes 0x55 and then one byte 0xD5.
- R5: After 0xD5 come these bytes in order: the destination address FF FF FF FF FF FF; the source address 02 00 00 A1 B2 C3; the EtherType 08 00. Then the IPv4 header: 45 00, total length, 00 00, 40 00, 40 11, checksum, source address C0 A8 45 0A, destination address C0 A8 45 01. Then the UDP header: ports 1F 90 and 1F 91, length, 00 00.
- R6: For a payload of N bytes, the IPv4 total length is 28+N and the UDP length is 8+N, each sent high byte first. The UDP checksum is sent as 00 00.
- R7: The IPv4 checksum is the ones'-complement of the ones'-complement sum of the ten 16-bit header words, with the checksum word taken as zero. It is sent high byte first.
- R8: The payload bytes follow the UDP header. If N is less than 18, zero bytes follow the payload until 18 bytes have been sent after the UDP header.
- R9: Four CRC bytes end the frame. The CRC uses the reflected polynomial 0xEDB88320 and starts at 0xFFFFFFFF. It covers every byte from the destination address to the last payload or pad byte. The bit-inverted result is sent least significant byte first.
- R10: After the last CRC nibble, tx_en is 0 and txd is 0. busy stays high for 24 cycles after tx_en falls, and then the payload store is empty.
- R11: Payload bytes offered while busy is high are not stored, and they do not appear in any later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, 25 MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| pl_data | input | 8 | Payload byte |
| pl_valid | input | 1 | pl_data holds a byte this cycle |
| pl_last | input | 1 | This byte is the final one of the payload |
| start | input | 1 | Request to send the stored payload |
| tx_en | output | 1 | MII transmit enable |
| txd | output | 4 | MII transmit nibble |
| busy | output | 1 | A frame or its idle gap is in progress |

## Verification
The assertions assume that the payload length cannot change while busy is high. They also assume that tx_en cannot rise before busy does. Both hold only because the block drops every write and start request during a frame. The stimulus tests exactly these conditions. It drives payload bytes, last flags and a start request in the middle of a frame and during the gap. It then shows at the ports that the next frame carries only the bytes loaded after busy fell. It also offers more bytes than the store holds, and issues a start with an empty store.

// File: rtl/udp_tx_pkg.sv
package udp_tx_pkg;

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_BODY, ST_FCS, ST_GAP} tx_state_t;

  localparam int PRE_BYTES = 8;
  localparam int HDR_BYTES = 42;   // 14 link + 20 IPv4 + 8 UDP
  localparam int MIN_DATA  = 18;   // 46-byte link minimum less 28 header bytes
  localparam int FCS_BYTES = 4;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [47:0] SRC_MAC  = 48'h0200_00A1_B2C3;
  localparam logic [31:0] SRC_IP   = 32'hC0A8_450A;
  localparam logic [31:0] DST_IP   = 32'hC0A8_4501;
  localparam logic [15:0] SRC_PORT = 16'h1F90;
  localparam logic [15:0] DST_PORT = 16'h1F91;

  function automatic logic [31:0] crc_next(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  function automatic logic [15:0] ip_csum(input logic [15:0] tot_len);
    logic [19:0] s;
    s = 20'h04500 + {4'd0, tot_len} + 20'h04000 + 20'h04011
      + {4'd0, SRC_IP[31:16]} + {4'd0, SRC_IP[15:0]}
      + {4'd0, DST_IP[31:16]} + {4'd0, DST_IP[15:0]};
    s = {4'd0, s[15:0]} + {16'd0, s[19:16]};
    s = {4'd0, s[15:0]} + {16'd0, s[19:16]};
    return ~s[15:0];
  endfunction

  function automatic logic [7:0] hdr_byte(input int idx, input logic [15:0] ip_len,
                                          input logic [15:0] udp_len, input logic [15:0] csum);
    logic [7:0] v;
    v = 8'h00;
    if (idx < 6) v = 8'hFF;
    else if (idx < 12) v = SRC_MAC[8*(11-idx) +: 8];
    else if (idx >= 26 && idx < 30) v = SRC_IP[8*(29-idx) +: 8];
    else if (idx >= 30 && idx < 34) v = DST_IP[8*(33-idx) +: 8];
    else begin
      case (idx)
        12: v = 8'h08;
        14: v = 8'h45;
        16: v = ip_len[15:8];
        17: v = ip_len[7:0];
        20: v = 8'h40;
        22: v = 8'h40;
        23: v = 8'h11;
        24: v = csum[15:8];
        25: v = csum[7:0];
        34: v = SRC_PORT[15:8];
        35: v = SRC_PORT[7:0];
        36: v = DST_PORT[15:8];
        37: v = DST_PORT[7:0];
        38: v = udp_len[15:8];
        39: v = udp_len[7:0];
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/udp_tx_buf.sv
module udp_tx_buf #(
  parameter int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             wr_last,
  input  logic             clear,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic [LEN_W-1:0] count,
  output logic             loaded
);
  logic [7:0] mem [DEPTH];
  logic       room;
  logic       do_store;

  assign room     = count < LEN_W'(DEPTH);
  assign do_store = wr_en && !loaded && room && !clear;
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (do_store) mem[count[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      loaded <= 1'b0;
    end else if (clear) begin
      count  <= '0;
      loaded <= 1'b0;
    end else if (wr_en && !loaded) begin
      if (room) count <= count + 1'b1;
      if (wr_last) loaded <= 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LEN_W'(DEPTH)); // R2
  AST_LOADED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    loaded && !clear |=> $stable(count)); // R2

endmodule

// File: rtl/udp_tx_crc.sv
module udp_tx_crc
  import udp_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [31:0] crc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= 32'hFFFF_FFFF;
    else if (init) crc_q <= 32'hFFFF_FFFF;
    else if (en)   crc_q <= crc_next(crc_q, data);
  end

  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !init && !en |=> $stable(crc_q)); // R9

endmodule

// File: rtl/mii_udp_tx.sv
module mii_udp_tx
  import udp_tx_pkg::*;
#(
  parameter int MAX_PAYLOAD = 64,
  parameter int GAP_CYCLES  = 25,
  localparam int AW    = $clog2(MAX_PAYLOAD),
  localparam int LEN_W = $clog2(MAX_PAYLOAD + 1),
  localparam int IDX_W = $clog2(HDR_BYTES + MAX_PAYLOAD + MIN_DATA + 1),
  localparam int GAP_W = $clog2(GAP_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] pl_data,
  input  logic       pl_valid,
  input  logic       pl_last,
  input  logic       start,
  output logic       tx_en,
  output logic [3:0] txd,
  output logic       busy
);
  tx_state_t        state;
  logic [IDX_W-1:0] idx;
  logic             ph;
  logic [GAP_W-1:0] gap_cnt;
  logic             tx_en_q;
  logic [3:0]       txd_q;

  logic [LEN_W-1:0] pay_len;
  logic             loaded;
  logic [7:0]       rd_data;
  logic [31:0]      crc_q;
  logic [31:0]      crc_sh;

  // named internal events
  logic             launch;
  logic             in_frame;
  logic             byte_step;
  logic             seg_last;
  logic             gap_done;
  logic             crc_en;

  logic [15:0]      ip_len, udp_len, ip_sum;
  logic [IDX_W-1:0] pay_off, data_len, body_len;
  logic [7:0]       cur_byte;

  assign busy      = (state != ST_IDLE);
  assign in_frame  = (state == ST_PRE) || (state == ST_BODY) || (state == ST_FCS);
  assign launch    = (state == ST_IDLE) && start && loaded;
  assign byte_step = in_frame && ph;
  assign gap_done  = (state == ST_GAP) && (gap_cnt == GAP_W'(GAP_CYCLES - 1));
  assign crc_en    = (state == ST_BODY) && ph;

  assign ip_len   = 16'(HDR_BYTES - 14) + 16'(pay_len);
  assign udp_len  = 16'd8 + 16'(pay_len);
  assign ip_sum   = ip_csum(ip_len);
  assign data_len = (pay_len < LEN_W'(MIN_DATA)) ? IDX_W'(MIN_DATA) : IDX_W'(pay_len);
  assign body_len = IDX_W'(HDR_BYTES) + data_len;
  assign pay_off  = idx - IDX_W'(HDR_BYTES);
  assign crc_sh   = crc_q >> {idx[1:0], 3'b000};

  always_comb begin
    seg_last = 1'b0;
    case (state)
      ST_PRE:  seg_last = (idx == IDX_W'(PRE_BYTES - 1));
      ST_BODY: seg_last = (idx == body_len - 1'b1);
      ST_FCS:  seg_last = (idx == IDX_W'(FCS_BYTES - 1));
      default: seg_last = 1'b0;
    endcase
  end

  always_comb begin
    cur_byte = 8'h00;
    case (state)
      ST_PRE:  cur_byte = (idx == IDX_W'(PRE_BYTES - 1)) ? 8'hD5 : 8'h55;
      ST_BODY: begin
        if (idx < IDX_W'(HDR_BYTES)) cur_byte = hdr_byte(int'(idx), ip_len, udp_len, ip_sum);
        else if (pay_off < IDX_W'(pay_len)) cur_byte = rd_data;
      end
      ST_FCS:  cur_byte = ~crc_sh[7:0];
      default: cur_byte = 8'h00;
    endcase
  end

  udp_tx_buf #(.DEPTH(MAX_PAYLOAD)) i_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(pl_valid && !busy), .wr_data(pl_data), .wr_last(pl_last),
    .clear(gap_done), .rd_addr(pay_off[AW-1:0]), .rd_data(rd_data),
    .count(pay_len), .loaded(loaded)
  );

  udp_tx_crc i_crc (
    .clk(clk), .rst_n(rst_n), .init(launch), .en(crc_en),
    .data(cur_byte), .crc_q(crc_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      ph      <= 1'b0;
      gap_cnt <= '0;
      tx_en_q <= 1'b0;
      txd_q   <= 4'h0;
    end else begin
      tx_en_q <= in_frame;
      txd_q   <= in_frame ? (ph ? cur_byte[7:4] : cur_byte[3:0]) : 4'h0;
      case (state)
        ST_IDLE: if (launch) begin
          state <= ST_PRE;
          idx   <= '0;
          ph    <= 1'b0;
        end
        ST_PRE, ST_BODY, ST_FCS: begin
          ph <= ~ph;
          if (byte_step) begin
            if (seg_last) begin
              idx <= '0;
              if (state == ST_PRE)       state <= ST_BODY;
              else if (state == ST_BODY) state <= ST_FCS;
              else begin
                state   <= ST_GAP;
                gap_cnt <= '0;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (gap_done) state <= ST_IDLE;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_en = tx_en_q;
  assign txd   = txd_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_en); // R10
  AST_TXD_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> txd == 4'h0); // R10
  AST_SFD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> txd == 4'h5); // R4
  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> busy); // R10
  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(pay_len)); // R11
  AST_LAUNCH_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(busy)); // R3

endmodule

// File: tb/test_mii_udp_tx.sv
module test_mii_udp_tx;
  localparam int MAXP = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pl_data = 8'h00;
  logic       pl_valid = 1'b0;
  logic       pl_last = 1'b0;
  logic       start = 1'b0;
  logic       tx_en, busy;
  logic [3:0] txd;

  int errors = 0;
  int checks = 0;
  int pay[$];
  int frame[$];

  always #10 clk = ~clk;

  mii_udp_tx #(.MAX_PAYLOAD(MAXP)) i_mii_udp_tx (
    .clk(clk), .rst_n(rst_n), .pl_data(pl_data), .pl_valid(pl_valid),
    .pl_last(pl_last), .start(start), .tx_en(tx_en), .txd(txd), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void push16(int v);
    frame.push_back((v >> 8) & 255);
    frame.push_back(v & 255);
  endfunction

  // reference frame built from the requirements
  function automatic void build_frame();
    int n, s, crc, ipstart;
    int hdr[$];
    n = pay.size();
    frame.delete();
    for (int i = 0; i < 7; i++) frame.push_back(8'h55);
    frame.push_back(8'hD5);
    for (int i = 0; i < 6; i++) frame.push_back(8'hFF);
    frame.push_back(8'h02); frame.push_back(8'h00); frame.push_back(8'h00);
    frame.push_back(8'hA1); frame.push_back(8'hB2); frame.push_back(8'hC3);
    push16(16'h0800);
    hdr = '{16'h4500, 28 + n, 16'h0000, 16'h4000, 16'h4011, 16'h0000,
            16'hC0A8, 16'h450A, 16'hC0A8, 16'h4501};
    s = 0;
    foreach (hdr[i]) s += hdr[i];
    while (s > 16'hFFFF) s = (s & 16'hFFFF) + (s >> 16);
    hdr[5] = (~s) & 16'hFFFF;
    ipstart = frame.size();
    foreach (hdr[i]) push16(hdr[i]);
    push16(16'h1F90); push16(16'h1F91); push16(8 + n); push16(0);
    foreach (pay[i]) frame.push_back(pay[i]);
    for (int i = n; i < 18; i++) frame.push_back(0);
    crc = 32'hFFFFFFFF;
    for (int i = 8; i < frame.size(); i++) begin
      crc = crc ^ frame[i];
      for (int b = 0; b < 8; b++)
        crc = (crc & 1) ? ((crc >>> 1) & 32'h7FFFFFFF) ^ 32'hEDB88320 : ((crc >>> 1) & 32'h7FFFFFFF);
    end
    crc = ~crc;
    for (int i = 0; i < 4; i++) frame.push_back((crc >> (8 * i)) & 255);
    if (ipstart != 22) $display("model layout mismatch");
  endfunction

  function automatic string req_of(int bi, int n);
    int dl;
    dl = (n < 18) ? 18 : n;
    if (bi < 8) return "R4";
    if (bi == 24 || bi == 25 || bi == 46 || bi == 47) return "R6";
    if (bi == 32 || bi == 33) return "R7";
    if (bi < 50) return "R5";
    if (bi < 50 + n) return "R2";
    if (bi < 50 + dl) return "R8";
    return "R9";
  endfunction

  task automatic load(input int offer, input int seed);
    pay.delete();
    for (int i = 0; i < offer; i++) begin
      @(negedge clk);
      pl_valid = 1'b1;
      pl_data  = 8'((seed + 37 * i) & 255);
      pl_last  = (i == offer - 1);
      if (i < MAXP) pay.push_back((seed + 37 * i) & 255);
    end
    @(negedge clk);
    pl_valid = 1'b0;
    pl_last  = 1'b0;
  endtask

  task automatic send_and_check(input bit junk);
    int nib, gapc;
    build_frame();
    nib = 2 * frame.size();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R3", "busy one cycle after start", busy, 1);
    check(tx_en == 1'b0, "R3", "tx_en one cycle after start", tx_en, 0);
    for (int k = 0; k < nib; k++) begin
      int exp;
      @(negedge clk);
      exp = (k % 2) ? (frame[k / 2] >> 4) & 15 : frame[k / 2] & 15;
      check(tx_en == 1'b1, req_of(k / 2, pay.size()), "tx_en in frame", tx_en, 1);
      check(txd == 4'(exp), req_of(k / 2, pay.size()), $sformatf("nibble %0d", k), txd, exp);
      if (junk) begin  // R11 and R3: writes and starts while busy
        pl_valid = 1'b1;
        pl_data  = 8'h3C;
        pl_last  = (k % 5 == 0);
        start    = (k == 10);
      end
    end
    @(negedge clk);
    check(tx_en == 1'b0, "R10", "tx_en after CRC", tx_en, 0);
    check(txd == 4'h0, "R10", "txd after CRC", txd, 0);
    gapc = 0;
    while (busy && gapc < 100) begin
      if (tx_en) check(1'b0, "R10", "tx_en in gap", tx_en, 0);
      gapc++;
      @(negedge clk);
    end
    pl_valid = 1'b0;
    pl_last  = 1'b0;
    start    = 1'b0;
    check(gapc == 24, "R10", "busy cycles after tx_en fell", gapc, 24);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tx_en == 1'b0, "R1", "tx_en in reset", tx_en, 0);
    check(txd == 4'h0, "R1", "txd in reset", txd, 0);
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_en == 1'b0 && busy == 1'b0, "R1", "idle after reset", {tx_en, busy}, 0);

    // R3: start with nothing loaded has no effect
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R3", "busy after empty start", busy, 0);
    check(tx_en == 1'b0, "R3", "tx_en after empty start", tx_en, 0);

    load(5, 8'h11);  send_and_check(1'b0);   // R8 padded payload
    load(18, 8'h42); send_and_check(1'b1);   // R11 junk while busy
    load(40, 8'h07); send_and_check(1'b1);   // R6 R7 other length
    load(70, 8'hC8); send_and_check(1'b0);   // R2 bytes beyond 64 dropped
    load(1, 8'hEE);  send_and_check(1'b0);   // R8 single byte

    // R10: store empty after the gap, a start does nothing
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && tx_en == 1'b0, "R10", "store empty after gap", {busy, tx_en}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule